// File: doc/BRIEF.md
# Remote Terminal Built-In-Test Status Register

This block keeps the 16-bit built-in-test word of a MIL-STD-1553B remote terminal. The protocol engine sends it single-cycle fault strobes: transmitter timeout (with the bus it occurred on), subsystem handshake failure, loop-test error, word count low or high, shutdown of either bus, and terminal-flag inhibit. The engine also sends each accepted command word with a valid strobe. From that command stream the block itself detects illegal-command, illegal T/R and illegal-broadcast conditions, and it decides which bits clear on which commands.

The register word is always visible on `bit_word`, ready to be sent in a transmit-BIT-word reply. A small self-test timer checks that the transmitter timeout mechanism fires inside a fixed window, measured in microsecond ticks. The word is updated one clock edge after the cycle that carries the strobe or the command.

Top module: `rt_bit_register`

## Requirements
- R1: Bit positions are: 0 transmitter timeout, 1 subsystem handshake failure, 2 loop-test failure, 3 illegal T/R, 4 illegal command, 5 word count low, 6 word count high, 7 illegal broadcast, 8 bus 0 shutdown, 9 bus 1 shutdown, 11 terminal flag inhibited, 12 timeout on bus 0, 13 timeout on bus 1. Bits 15, 14 and 10 always read zero.
- R2: `rst_n` low clears the whole word. A legal reset-remote-terminal mode command also clears the whole word. That command is subaddress 0 or 31, code 01000, T/R 1, not vetoed and not otherwise illegal.
- R3: Bits 0, 1, 2, 8, 9, 11, 12 and 13 stay set until one of the two whole-word clears in R2.
- R4: Any other valid command clears bits 3 to 7. The command word is bits 15:11 RT address, bit 10 T/R, bits 9:5 subaddress and bits 4:0 word count or mode code.
- R5: A legal transmit-status (code 00010), transmit-last-command (10010) or transmit-BIT-word (10011) mode command with T/R 1 leaves every bit unchanged.
- R6: Bit 4 sets on a valid command when any of these holds: `ss_veto_n` is low; a reserved mode code (01001 to 01111, 10110 to 11111) arrives while `rsvd_reject` is high; or a shutdown mode code (00100 or 10100) arrives while `sd_permit` is low.
- R7: Bit 7 sets when a command to RT address 31 requires the terminal to transmit. That is a non-mode command with T/R 1, or a T/R 1 mode command with code 00000, 00010, 10000, 10010 or 10011.
- R8: Bit 3 sets when a non-reserved mode command has the wrong T/R. Codes 10001, 10100 and 10101 need T/R 0. All other non-reserved codes need T/R 1.
- R9: After `st_start`, bit 0 sets if `st_fire` arrives while the tick count is below 660, or if the count passes 800 with no `st_fire`.
- R10: When a set and a clear reach the same bit in the same cycle, the set wins.
- R11: `ev_tx_timeout` sets bit 0 and also bit 12 (`tx_bus` 0) or bit 13 (`tx_bus` 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up clear, active low |
| cmd_valid | input | 1 | Command word accepted this cycle |
| cmd_word | input | 16 | Accepted command word |
| ss_veto_n | input | 1 | Subsystem marks command illegal when low |
| rsvd_reject | input | 1 | Reserved mode codes treated as illegal |
| sd_permit | input | 1 | Shutdown mode codes permitted |
| ev_tx_timeout | input | 1 | Transmitter timeout strobe |
| tx_bus | input | 1 | Bus of the timeout |
| ev_hs_fail | input | 1 | Handshake failure strobe |
| ev_loop_fail | input | 1 | Loop-test failure strobe |
| ev_wc_low | input | 1 | Too few data words strobe |
| ev_wc_high | input | 1 | Too many data words strobe |
| ev_bus_shut | input | 2 | Bus 1/0 shutdown strobes |
| ev_tf_inhibit | input | 1 | Terminal flag inhibited strobe |
| st_start | input | 1 | Self-test timer start |
| st_fire | input | 1 | Timeout mechanism fired in self-test |
| us_tick | input | 1 | Microsecond tick |
| bit_word | output | 16 | Built-in-test word |

## Verification
A wrong internal state shows on `bit_word` one edge after the cycle that caused it, because the word is the register itself. The bench compares the full word after every cycle. So a stuck bit, a missed clear or a clear applied to an exempt command is caught in the same cycle it appears. A self-test timer that is off by one tick shows only when `st_fire` lands on a window boundary. For that reason the fire points are placed exactly at counts 659, 660 and 800, and one case gives no fire at all.

// File: rtl/rt_bit_pkg.sv
package rt_bit_pkg;
    localparam int WORD_W = 16;

    // bit positions in the built-in-test word
    localparam int B_TTO     = 0;
    localparam int B_HSF     = 1;
    localparam int B_LOOP    = 2;
    localparam int B_ILL_TR  = 3;
    localparam int B_ILL_CMD = 4;
    localparam int B_WC_LO   = 5;
    localparam int B_WC_HI   = 6;
    localparam int B_ILL_BC  = 7;
    localparam int B_SHUT0   = 8;
    localparam int B_SHUT1   = 9;
    localparam int B_TF_INH  = 11;
    localparam int B_TTO0    = 12;
    localparam int B_TTO1    = 13;

    localparam logic [WORD_W-1:0] CMD_CLEAR_MASK = 16'h00F8;

    typedef struct packed {
        logic [4:0] rt;
        logic       tr;
        logic [4:0] sa;
        logic [4:0] mc;
    } cmd_t;

    localparam logic [4:0] MC_DYN_BUS  = 5'd0;
    localparam logic [4:0] MC_TX_STAT  = 5'd2;
    localparam logic [4:0] MC_XMTR_SD  = 5'd4;
    localparam logic [4:0] MC_RESET    = 5'd8;
    localparam logic [4:0] MC_TX_VEC   = 5'd16;
    localparam logic [4:0] MC_SYNC_D   = 5'd17;
    localparam logic [4:0] MC_TX_LAST  = 5'd18;
    localparam logic [4:0] MC_TX_BIT   = 5'd19;
    localparam logic [4:0] MC_SEL_SD   = 5'd20;
    localparam logic [4:0] MC_SEL_OVR  = 5'd21;
endpackage

// File: rtl/rt_cmd_decode.sv
module rt_cmd_decode
    import rt_bit_pkg::*;
#(
    parameter logic [4:0] BCAST_ADDR = 5'd31
) (
    input  logic        cmd_valid_i,
    input  logic [15:0] cmd_word_i,
    input  logic        ss_veto_n_i,
    input  logic        rsvd_reject_i,
    input  logic        sd_permit_i,
    output logic        ill_tr_o,
    output logic        ill_cmd_o,
    output logic        ill_bc_o,
    output logic        exempt_o,
    output logic        reset_cmd_o
);
    cmd_t c;
    logic is_mode, is_bcast, is_rsvd, tr_care, tr_need, is_sd, needs_tx, clean;

    always_comb begin
        c        = cmd_t'(cmd_word_i);
        is_mode  = (c.sa == 5'd0) || (c.sa == 5'd31);
        is_bcast = (c.rt == BCAST_ADDR);
        is_rsvd  = is_mode && (((c.mc >= 5'd9) && (c.mc <= 5'd15)) || (c.mc >= 5'd22));
        tr_care  = is_mode && !is_rsvd;
        tr_need  = !((c.mc == MC_SYNC_D) || (c.mc == MC_SEL_SD) || (c.mc == MC_SEL_OVR));
        is_sd    = is_mode && ((c.mc == MC_XMTR_SD) || (c.mc == MC_SEL_SD));
        if (is_mode)
            needs_tx = c.tr && ((c.mc == MC_DYN_BUS) || (c.mc == MC_TX_STAT) ||
                                (c.mc == MC_TX_VEC)  || (c.mc == MC_TX_LAST) ||
                                (c.mc == MC_TX_BIT));
        else
            needs_tx = c.tr;

        ill_tr_o  = cmd_valid_i && tr_care && (c.tr != tr_need);
        ill_cmd_o = cmd_valid_i && (!ss_veto_n_i || (is_rsvd && rsvd_reject_i) ||
                                    (is_sd && !sd_permit_i));
        ill_bc_o  = cmd_valid_i && is_bcast && needs_tx;
        clean     = !ill_tr_o && !ill_cmd_o && !ill_bc_o;

        exempt_o    = cmd_valid_i && is_mode && c.tr && clean &&
                      ((c.mc == MC_TX_STAT) || (c.mc == MC_TX_LAST) || (c.mc == MC_TX_BIT));
        reset_cmd_o = cmd_valid_i && is_mode && (c.mc == MC_RESET) && clean;
    end
endmodule

// File: rtl/rt_selftest_timer.sv
module rt_selftest_timer #(
    parameter int MIN_TICKS = 660,
    parameter int MAX_TICKS = 800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic fire_i,
    input  logic tick_i,
    output logic fail_o
);
    localparam int CW = $clog2(MAX_TICKS + 2);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] count;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        fail_o = 1'b0;
        if (start_i) begin
            tmr_d.active = 1'b1;
            tmr_d.count  = '0;
        end else if (tmr_q.active) begin
            if (fire_i) begin
                fail_o       = (tmr_q.count < CW'(MIN_TICKS));
                tmr_d.active = 1'b0;
            end else if (tick_i) begin
                if (tmr_q.count == CW'(MAX_TICKS)) begin
                    fail_o       = 1'b1;
                    tmr_d.active = 1'b0;
                end else begin
                    tmr_d.count = tmr_q.count + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R9: a failure is only reported while a window is being timed
    assert_fail_only_armed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> tmr_q.active);
    // R9: the count never runs past the upper limit
    assert_count_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.count <= CW'(MAX_TICKS));
endmodule

// File: rtl/rt_bit_register.sv
module rt_bit_register
    import rt_bit_pkg::*;
#(
    parameter logic [4:0] BCAST_ADDR = 5'd31,
    parameter int         ST_MIN_US  = 660,
    parameter int         ST_MAX_US  = 800
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [15:0] cmd_word,
    input  logic        ss_veto_n,
    input  logic        rsvd_reject,
    input  logic        sd_permit,
    input  logic        ev_tx_timeout,
    input  logic        tx_bus,
    input  logic        ev_hs_fail,
    input  logic        ev_loop_fail,
    input  logic        ev_wc_low,
    input  logic        ev_wc_high,
    input  logic [1:0]  ev_bus_shut,
    input  logic        ev_tf_inhibit,
    input  logic        st_start,
    input  logic        st_fire,
    input  logic        us_tick,
    output logic [15:0] bit_word
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
    } bit_state_t;

    bit_state_t st_d, st_q;
    logic ill_tr, ill_cmd, ill_bc, exempt, reset_cmd, st_fail;
    logic [WORD_W-1:0] set_vec;

    rt_cmd_decode #(.BCAST_ADDR(BCAST_ADDR)) dec_i (
        .cmd_valid_i  (cmd_valid),
        .cmd_word_i   (cmd_word),
        .ss_veto_n_i  (ss_veto_n),
        .rsvd_reject_i(rsvd_reject),
        .sd_permit_i  (sd_permit),
        .ill_tr_o     (ill_tr),
        .ill_cmd_o    (ill_cmd),
        .ill_bc_o     (ill_bc),
        .exempt_o     (exempt),
        .reset_cmd_o  (reset_cmd)
    );

    rt_selftest_timer #(.MIN_TICKS(ST_MIN_US), .MAX_TICKS(ST_MAX_US)) tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(st_start),
        .fire_i (st_fire),
        .tick_i (us_tick),
        .fail_o (st_fail)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[B_TTO]     = ev_tx_timeout || st_fail;
        set_vec[B_HSF]     = ev_hs_fail;
        set_vec[B_LOOP]    = ev_loop_fail;
        set_vec[B_ILL_TR]  = ill_tr;
        set_vec[B_ILL_CMD] = ill_cmd;
        set_vec[B_WC_LO]   = ev_wc_low;
        set_vec[B_WC_HI]   = ev_wc_high;
        set_vec[B_ILL_BC]  = ill_bc;
        set_vec[B_SHUT0]   = ev_bus_shut[0];
        set_vec[B_SHUT1]   = ev_bus_shut[1];
        set_vec[B_TF_INH]  = ev_tf_inhibit;
        set_vec[B_TTO0]    = ev_tx_timeout && !tx_bus;
        set_vec[B_TTO1]    = ev_tx_timeout && tx_bus;

        st_d = st_q;
        if (reset_cmd)
            st_d.word = '0;
        else if (cmd_valid && !exempt)
            st_d.word = st_q.word & ~CMD_CLEAR_MASK;
        // sets are applied last so they win over any clear
        st_d.word = st_d.word | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_word = st_q.word;

    assert_unused_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_word[15:14] == 2'b00) && !bit_word[10]);
    assert_reset_cmd_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reset_cmd && (set_vec == '0) |=> bit_word == '0);
    assert_sticky_tto_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_word[B_TTO] && !reset_cmd |=> bit_word[B_TTO]);
    assert_exempt_untouched_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exempt && (set_vec == '0) |=> $stable(bit_word));
    assert_ill_bc_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ill_bc |=> bit_word[B_ILL_BC]);
    assert_ill_tr_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ill_tr |=> bit_word[B_ILL_TR]);
    assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && ev_wc_low |=> bit_word[B_WC_LO]);
    assert_tto_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_timeout |=> bit_word[B_TTO] && (bit_word[B_TTO0] || bit_word[B_TTO1]));
endmodule

// File: tb/rt_bit_register_tb.sv
module rt_bit_register_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [15:0] cmd_word;
    logic        ss_veto_n, rsvd_reject, sd_permit;
    logic        ev_tx_timeout, tx_bus, ev_hs_fail, ev_loop_fail;
    logic        ev_wc_low, ev_wc_high, ev_tf_inhibit;
    logic [1:0]  ev_bus_shut;
    logic        st_start, st_fire, us_tick;
    logic [15:0] bit_word;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    logic [15:0] exp_w;

    always #4 clk = ~clk; // 125 MHz

    rt_bit_register dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .ss_veto_n(ss_veto_n), .rsvd_reject(rsvd_reject), .sd_permit(sd_permit),
        .ev_tx_timeout(ev_tx_timeout), .tx_bus(tx_bus), .ev_hs_fail(ev_hs_fail),
        .ev_loop_fail(ev_loop_fail), .ev_wc_low(ev_wc_low), .ev_wc_high(ev_wc_high),
        .ev_bus_shut(ev_bus_shut), .ev_tf_inhibit(ev_tf_inhibit),
        .st_start(st_start), .st_fire(st_fire), .us_tick(us_tick), .bit_word(bit_word)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_fails = n_fails + 1;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    // reference next-word computed from the requirement text
    function automatic logic [15:0] ref_next(input logic [15:0] cur);
        logic [4:0] rt, sa, mc;
        logic tr, md, rsv, bad_tr, bad_cmd, bad_bc, tx_need, ok;
        logic [15:0] n;
        rt = cmd_word[15:11]; tr = cmd_word[10]; sa = cmd_word[9:5]; mc = cmd_word[4:0];
        md  = (sa == 5'd0) || (sa == 5'd31);
        rsv = md && ((mc inside {[5'd9:5'd15]}) || (mc inside {[5'd22:5'd31]}));
        bad_tr = 1'b0;
        if (md && !rsv) begin
            if (mc == 5'd17 || mc == 5'd20 || mc == 5'd21) bad_tr = tr;
            else                                           bad_tr = !tr;
        end
        bad_cmd = !ss_veto_n || (rsv && rsvd_reject) ||
                  (md && (mc == 5'd4 || mc == 5'd20) && !sd_permit);
        tx_need = md ? (tr && (mc inside {5'd0, 5'd2, 5'd16, 5'd18, 5'd19})) : tr;
        bad_bc  = (rt == 5'd31) && tx_need;
        ok = !bad_tr && !bad_cmd && !bad_bc;
        n = cur;
        if (cmd_valid) begin
            if (md && mc == 5'd8 && ok)                                     n = 16'h0;
            else if (!(md && tr && ok && (mc inside {5'd2, 5'd18, 5'd19}))) n[7:3] = 5'b0;
            if (bad_tr)  n[3] = 1'b1;
            if (bad_cmd) n[4] = 1'b1;
            if (bad_bc)  n[7] = 1'b1;
        end
        if (ev_tx_timeout) begin n[0] = 1'b1; n[tx_bus ? 13 : 12] = 1'b1; end
        if (ev_hs_fail)     n[1]  = 1'b1;
        if (ev_loop_fail)   n[2]  = 1'b1;
        if (ev_wc_low)      n[5]  = 1'b1;
        if (ev_wc_high)     n[6]  = 1'b1;
        if (ev_bus_shut[0]) n[8]  = 1'b1;
        if (ev_bus_shut[1]) n[9]  = 1'b1;
        if (ev_tf_inhibit)  n[11] = 1'b1;
        return n;
    endfunction

    task automatic idle_inputs();
        cmd_valid = 0; cmd_word = 16'h0; ss_veto_n = 1; rsvd_reject = 0; sd_permit = 1;
        ev_tx_timeout = 0; tx_bus = 0; ev_hs_fail = 0; ev_loop_fail = 0;
        ev_wc_low = 0; ev_wc_high = 0; ev_bus_shut = 2'b00; ev_tf_inhibit = 0;
        st_start = 0; st_fire = 0;
    endtask

    task automatic check(input string req, input logic [15:0] exp);
        n_checks++;
        if (bit_word !== exp) begin
            n_fails++;
            $display("FAIL %s: bit_word=%h expected=%h", req, bit_word, exp);
        end
    endtask

    // apply current inputs for one edge, then compare against the model
    task automatic step(input string req);
        exp_w = ref_next(exp_w);
        @(negedge clk);
        check(req, exp_w);
        idle_inputs();
    endtask

    task automatic cmd(input logic [4:0] rt, input logic tr, input logic [4:0] sa,
                       input logic [4:0] mc, input string req);
        cmd_valid = 1; cmd_word = {rt, tr, sa, mc};
        step(req);
    endtask

    task automatic self_test(input int k, input logic expect_fail);
        cmd(5'd5, 1'b1, 5'd0, 5'd8, "R2 clear before self test");
        st_start = 1;
        @(negedge clk);
        st_start = 0;
        if (k > 0) begin
            repeat (k - 1) @(negedge clk);
            st_fire = 1;
            @(negedge clk);
            st_fire = 0;
        end else begin
            repeat (805) @(negedge clk);
        end
        exp_w = {15'h0, expect_fail};
        check($sformatf("R9 self test fire at edge %0d", k), exp_w);
    endtask

    initial begin
        idle_inputs();
        us_tick = 1;
        rst_n = 0;
        exp_w = 16'h0;
        repeat (3) @(negedge clk);
        check("R2 power-up clear", 16'h0);
        rst_n = 1;
        @(negedge clk);
        check("R2 idle after reset", 16'h0);

        ev_tx_timeout = 1; tx_bus = 1; step("R11 timeout bus 1");
        ev_tx_timeout = 1; tx_bus = 0; step("R11 timeout bus 0");
        ev_hs_fail = 1; ev_loop_fail = 1; ev_bus_shut = 2'b11; ev_tf_inhibit = 1;
        step("R1 sticky fault positions");
        cmd(5'd5, 1'b0, 5'd3, 5'd4, "R3 plain command keeps sticky bits");
        cmd(5'd31, 1'b1, 5'd3, 5'd2, "R7 broadcast transmit");
        cmd(5'd31, 1'b1, 5'd0, 5'd2, "R7 broadcast transmit-status");
        cmd(5'd5, 1'b0, 5'd3, 5'd1, "R4 clear on next command");
        ss_veto_n = 0; cmd(5'd5, 1'b0, 5'd3, 5'd1, "R6 subsystem veto");
        rsvd_reject = 1; cmd(5'd5, 1'b1, 5'd0, 5'd11, "R6 reserved code rejected");
        cmd(5'd5, 1'b1, 5'd0, 5'd11, "R6 reserved code allowed");
        sd_permit = 0; cmd(5'd5, 1'b1, 5'd31, 5'd4, "R6 shutdown not permitted");
        cmd(5'd5, 1'b1, 5'd0, 5'd17, "R8 sync-with-data wrong T/R");
        cmd(5'd5, 1'b1, 5'd0, 5'd19, "R5 transmit BIT word untouched");
        cmd(5'd5, 1'b1, 5'd0, 5'd2, "R5 transmit status untouched");
        cmd(5'd5, 1'b1, 5'd31, 5'd18, "R5 transmit last command untouched");
        cmd(5'd5, 1'b0, 5'd0, 5'd19, "R8 transmit BIT word with T/R 0");
        ev_wc_low = 1; cmd(5'd5, 1'b0, 5'd3, 5'd1, "R10 set wins over clear");
        ev_wc_high = 1; cmd(5'd5, 1'b1, 5'd0, 5'd8, "R10 set wins over reset command");
        cmd(5'd31, 1'b1, 5'd0, 5'd8, "R2 broadcast reset-RT clears");
        ss_veto_n = 0; cmd(5'd5, 1'b1, 5'd0, 5'd8, "R2 vetoed reset-RT does not clear");
        cmd(5'd5, 1'b1, 5'd0, 5'd8, "R2 legal reset-RT clears");

        self_test(200, 1'b1);
        self_test(660, 1'b1);
        self_test(661, 1'b0);
        self_test(801, 1'b0);
        self_test(0,   1'b1);
        cmd(5'd5, 1'b1, 5'd0, 5'd8, "R2 clear after self test");

        void'($urandom(32'd4242));
        for (int i = 0; i < 4000; i++) begin
            logic [4:0] sa_pick;
            cmd_valid   = ($urandom % 2) == 0;
            sa_pick     = ($urandom % 3 == 0) ? 5'd0 : (($urandom % 2 == 0) ? 5'd31 : 5'($urandom));
            cmd_word    = {($urandom % 4 == 0) ? 5'd31 : 5'd5, 1'($urandom), sa_pick, 5'($urandom)};
            ss_veto_n   = ($urandom % 8) != 0;
            rsvd_reject = 1'($urandom);
            sd_permit   = 1'($urandom);
            ev_tx_timeout = ($urandom % 16) == 0;
            tx_bus        = 1'($urandom);
            ev_hs_fail    = ($urandom % 16) == 0;
            ev_loop_fail  = ($urandom % 16) == 0;
            ev_wc_low     = ($urandom % 8) == 0;
            ev_wc_high    = ($urandom % 8) == 0;
            ev_bus_shut   = {($urandom % 16) == 0, ($urandom % 16) == 0};
            ev_tf_inhibit = ($urandom % 16) == 0;
            if ($urandom % 40 == 0) begin
                cmd_valid = 1; cmd_word = {5'd5, 1'b1, 5'd0, 5'd8}; ss_veto_n = 1;
            end
            step("R4 R6 R7 R8 R10 random mix");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule